// File: doc/BRIEF.md
# Multi-Mode Built-In Logic Block Observer Register

This block is an n-bit register whose flops serve four purposes, chosen cycle by cycle by a two-bit mode code. In system operation it behaves as a plain parallel register between two pieces of logic. In scan operation it forms a serial shift chain, so a seed can be shifted in and a result shifted out. In generator operation it runs as an autonomous linear-feedback shift register that produces pseudo-random stimulus. In signature operation it folds the parallel input into the shifting state, compacting a stream of responses into a single word.

Registers of this kind sit on both sides of a block of logic under test. One instance generates patterns while the other compacts responses, and the two swap roles to test the neighbouring block. The feedback polynomial is an elaboration-time tap mask. By default every stage takes part in the feedback. The register has no synchronous clear: it is emptied by shifting zeros through the scan path.

Top module: `bilbo_reg`

## Requirements
- R1: An active-low asynchronous reset (rst_n low) forces every bit of par_out to 0 at once, without waiting for a clock edge.
- R2: With mode code {mode_hi,mode_lo}=00 (scan), each clock moves bit i-1 into bit i and loads scan_in into bit 0.
- R3: scan_out always equals par_out[WIDTH-1], whatever the mode.
- R4: With mode code 01 (generator), each clock moves bit i-1 into bit i and loads the feedback into bit 0. The feedback is the XOR of every bit i whose TAPS[i] is 1; by default TAPS is all ones. par_in has no effect in this mode.
- R5: With mode code 10 (system), each clock loads par_in into par_out unchanged.
- R6: With mode code 11 (signature), each clock sets bit i to bit i-1 XOR par_in[i], and sets bit 0 to the feedback of R4 XOR par_in[0].
- R7: WIDTH clocks in scan mode with scan_in at 0 leave the register all zeros, from any starting state.
- R8: In generator mode a nonzero state never steps to the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_hi | input | 1 | Upper bit of the mode code |
| mode_lo | input | 1 | Lower bit of the mode code |
| par_in | input | WIDTH | Parallel data from the logic under test |
| scan_in | input | 1 | Serial input to bit 0 in scan mode |
| par_out | output | WIDTH | Register contents |
| scan_out | output | 1 | Serial output, the most significant bit |

## Verification
The assertions check these behaviours on every clock: the scan shift, the load in system mode, the neighbour shift in generator and signature modes, and the rule that a nonzero generator state never collapses to zero. The bench scenarios cover behaviour that spans many cycles or depends on stimulus. They check the exact generator sequence from a seeded value, that generation ignores par_in, a signature built over several response words, clearing by a run of zeros on the scan path, and a reset that arrives between clock edges.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

   // Mode code is {mode_hi, mode_lo}; the mapping is fixed.
   typedef enum logic [1:0] {
      MODE_SCAN = 2'b00,
      MODE_GEN  = 2'b01,
      MODE_SYS  = 2'b10,
      MODE_SIG  = 2'b11
   } bilbo_mode_e;

   function automatic bilbo_mode_e decode_mode(input logic hi, input logic lo);
      return bilbo_mode_e'({hi, lo});
   endfunction

endpackage

// File: rtl/bilbo_feedback.sv
module bilbo_feedback #(
   parameter int                 WIDTH = 8,
   parameter logic [WIDTH-1:0]   TAPS  = {WIDTH{1'b1}}
) (
   input  logic [WIDTH-1:0] state,
   output logic             fb
);
   localparam bit FULL_POLY = (TAPS == {WIDTH{1'b1}});

   generate
      if (FULL_POLY) begin : g_full
         // every stage contributes
         assign fb = ^state;
      end else begin : g_masked
         assign fb = ^(state & TAPS);
      end
   endgenerate

endmodule

// File: rtl/bilbo_stage.sv
module bilbo_stage
   import bilbo_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  bilbo_mode_e mode,
   input  logic        from_scan,
   input  logic        from_gen,
   input  logic        din,
   output logic        q
);
   logic nxt;

   always_comb begin
      unique case (mode)
         MODE_SCAN: nxt = from_scan;
         MODE_GEN:  nxt = from_gen;
         MODE_SYS:  nxt = din;
         MODE_SIG:  nxt = from_gen ^ din;
         default:   nxt = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= nxt;
   end

endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
   import bilbo_pkg::*;
#(
   parameter int               WIDTH = 8,
   parameter logic [WIDTH-1:0] TAPS  = {WIDTH{1'b1}}
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_hi,
   input  logic             mode_lo,
   input  logic [WIDTH-1:0] par_in,
   input  logic             scan_in,
   output logic [WIDTH-1:0] par_out,
   output logic             scan_out
);
   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < 2) begin : g_bad_width
         $error("bilbo_reg: WIDTH must be at least 2");
      end
      if (TAPS[WIDTH-1] != 1'b1) begin : g_bad_taps
         $error("bilbo_reg: TAPS must include the top stage");
      end
   endgenerate

   bilbo_mode_e      mode;
   logic [WIDTH-1:0] q;
   logic             fb;

   assign mode = decode_mode(mode_hi, mode_lo);

   bilbo_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) i_fb (
      .state (q),
      .fb    (fb)
   );

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic src_scan, src_gen;
         if (i == 0) begin : g_head
            assign src_scan = scan_in;
            assign src_gen  = fb;
         end else begin : g_body
            assign src_scan = q[i-1];
            assign src_gen  = q[i-1];
         end
         bilbo_stage i_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .mode      (mode),
            .from_scan (src_scan),
            .from_gen  (src_gen),
            .din       (par_in[i]),
            .q         (q[i])
         );
      end
   endgenerate

   assign par_out  = q;
   assign scan_out = q[MSB];

   // R1: reset holds the register empty
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_clear_r1: assert (par_out == '0)
            else $error("R1 reset did not clear register");
      end
   end

   // R2
   p_scan_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_SCAN |=> par_out == {$past(par_out[MSB-1:0]), $past(scan_in)});

   // R4
   p_gen_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_GEN |=> par_out[MSB:1] == $past(par_out[MSB-1:0]));

   // R5
   p_sys_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_SYS |=> par_out == $past(par_in));

   // R6
   p_sig_fold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_SIG |=> par_out[MSB:1] == ($past(par_out[MSB-1:0]) ^ $past(par_in[MSB:1])));

   // R8
   p_gen_no_lockup_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_GEN && par_out != '0) |=> par_out != '0);

endmodule

// File: tb/test_bilbo_reg.sv
module test_bilbo_reg;
   localparam int W = 8;

   typedef struct {
      logic [W-1:0] exp;
      string        req;
   } item_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         mode_hi = 1'b0, mode_lo = 1'b0;
   logic [W-1:0] par_in = '0;
   logic         scan_in = 1'b0;
   logic [W-1:0] par_out;
   logic         scan_out;

   int checks = 0;
   int errors = 0;
   item_t sb[$];
   logic [W-1:0] model = '0;

   always #2.5 clk = ~clk;

   bilbo_reg #(.WIDTH(W)) i_bilbo_reg (
      .clk(clk), .rst_n(rst_n), .mode_hi(mode_hi), .mode_lo(mode_lo),
      .par_in(par_in), .scan_in(scan_in), .par_out(par_out), .scan_out(scan_out)
   );

   function automatic logic [W-1:0] ref_next(input logic [1:0] m, input logic [W-1:0] s,
                                             input logic [W-1:0] d, input logic si);
      logic f;
      f = ^s;
      case (m)
         2'b00:   return {s[W-2:0], si};
         2'b01:   return {s[W-2:0], f};
         2'b10:   return d;
         default: return {s[W-2:0], f} ^ d;
      endcase
   endfunction

   task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // driver: one clock of stimulus, expected result queued for the monitor
   task automatic step(input logic [1:0] m, input logic [W-1:0] d, input logic si, input string req);
      item_t it;
      @(negedge clk);
      {mode_hi, mode_lo} = m;
      par_in  = d;
      scan_in = si;
      model   = ref_next(m, model, d, si);
      it.exp  = model;
      it.req  = req;
      sb.push_back(it);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            check(par_out, it.exp, it.req);
            check({{(W-1){1'b0}}, scan_out}, {{(W-1){1'b0}}, it.exp[W-1]}, "R3 scan_out");
         end
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [W-1:0] seed;
      logic [W-1:0] resp;
      #1;
      check(par_out, '0, "R1 reset state");
      check({{(W-1){1'b0}}, scan_out}, '0, "R3 scan_out at reset");
      repeat (2) @(negedge clk);
      rst_n = 1'b1;

      // R2: scan a seed in, MSB first
      seed = 8'hA5;
      for (int i = W - 1; i >= 0; i--) step(2'b00, 8'hFF, seed[i], "R2 scan shift");

      // R4 / R8: generator with noisy par_in
      for (int i = 0; i < 20; i++) step(2'b01, W'(i * 37 + 11), 1'b1, "R4 R8 generator");

      // R5: system loads
      step(2'b10, 8'h3C, 1'b0, "R5 system load");
      step(2'b10, 8'h00, 1'b1, "R5 system load");
      step(2'b10, 8'hFF, 1'b0, "R5 system load");
      step(2'b10, 8'h81, 1'b0, "R5 system load");

      // R6: signature over a response stream
      for (int i = 0; i < 12; i++) begin
         resp = W'(i * 73 + 5) ^ W'(i << 3);
         step(2'b11, resp, 1'b0, "R6 signature");
      end

      // R7: shift zeros to clear
      for (int i = 0; i < W; i++) step(2'b00, 8'hFF, 1'b0, "R7 scan clear");
      @(negedge clk);
      @(negedge clk);
      check(par_out, '0, "R7 cleared");

      // R1: asynchronous reset mid-cycle after loading a value
      step(2'b10, 8'h5A, 1'b0, "R5 system load");
      @(negedge clk);
      @(negedge clk);
      #1;
      rst_n = 1'b0;
      model = '0;
      #0.5;
      check(par_out, '0, "R1 async reset");
      @(negedge clk);
      rst_n = 1'b1;

      // R8 from a different seed, single set bit
      step(2'b10, 8'h01, 1'b0, "R5 system load");
      for (int i = 0; i < 16; i++) step(2'b01, 8'h00, 1'b0, "R4 R8 generator seed 01");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end

endmodule